// File: doc/BRIEF.md
# Victim/Aggressor Crosstalk Pattern Shaper

This block turns a one-bit base stream into a full-width test word for crosstalk stress on a data bus. One or more bit positions in each word are *victims*, and they carry the base bit. Every other bit is an *aggressor* and is driven by a programmed relation to that base bit. An aggressor can be held high, held low, follow the base bit, invert it, or carry a copy of it from up to 24 accepted words earlier. A further mode swaps the roles, so that the victim lags the aggressors.

The victim position can come from a global index. It can also rotate by one position per accepted word: within every nibble, within every byte, or across the whole bus. A pass-through mode hands a separately supplied base word to the output unchanged.

Each accepted word (`in_valid` high) is shaped and registered. It appears on `data_out` one cycle later, with `out_valid` high.

Top module: `vxt_shaper`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `data_out` are 0. The delay history is all zeros and the rotation position is 0.
- R2: A word accepted with `in_valid` high appears on `data_out` with `out_valid` high at the next clock edge. With `in_valid` low, `out_valid` is 0 and `data_out` holds its value. The history and the rotation position do not advance.
- R3: `mode` 0 (no victim) and the reserved `mode` 7 copy `base_word` to the output unchanged.
- R4: In `mode` 1, victim bits carry `base_bit` and aggressor bits are 1. In `mode` 2, victim bits carry `base_bit` and aggressor bits are 0.
- R5: In `mode` 3, every bit equals `base_bit`. In `mode` 4, victim bits carry `base_bit` and aggressor bits carry its inverse.
- R6: In `mode` 5, victim bits carry `base_bit`. Aggressor bits carry the base bit accepted N words earlier, where N = `dly_cyc`. N = 0 means the current bit. History from before reset reads as 0.
- R7: In `mode` 6, aggressor bits carry `base_bit`. Victim bits carry the base bit accepted N words earlier.
- R8: A `dly_cyc` value above 24 acts as 24.
- R9: With `vic_src` 0, the only victim is bit index `vic_bit`. If `vic_bit` is not below DATA_W, there is no victim and every bit is an aggressor.
- R10: With `vic_src` 1, the victim is bit P of every nibble, where P is the rotation position. P starts at 0 and advances by one per accepted word. After 3 it returns to 0.
- R11: With `vic_src` 2, the victim is bit P of every byte. P returns to 0 after 7.
- R12: With `vic_src` 3, the victim is the single bit P of the bus. P returns to 0 after DATA_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept one word this cycle |
| base_bit | input | 1 | Base stream bit for this word |
| base_word | input | DATA_W | Word passed through in modes 0 and 7 |
| mode | input | 3 | Aggressor relation: 0 none, 1 hold 1, 2 hold 0, 3 same, 4 inverse, 5 aggressor late, 6 victim late, 7 reserved |
| dly_cyc | input | 5 | Lag N in accepted words (0 to 24, clamped) |
| vic_src | input | 2 | Victim position: 0 global index, 1 per nibble, 2 per byte, 3 whole bus |
| vic_bit | input | 8 | Global victim bit index |
| out_valid | output | 1 | `data_out` holds a freshly shaped word |
| data_out | output | DATA_W | Shaped word |

## Verification
The bench builds the block with DATA_W = 16 and keeps the default history depth of 24. A 16-bit bus lets the whole-bus rotation wrap within a short run. It also makes an 8-bit global index of 20 point outside the bus, which exercises the no-victim case. The full-depth history is reached with a lag of 24, and again with the out-of-range value 31, which the block clamps to 24. Both runs use more than 24 accepted words, so the lagged bits include real history and not only reset zeros.

// File: rtl/vxt_pkg.sv
package vxt_pkg;
  typedef enum logic [2:0] {
    VM_OFF      = 3'd0,
    VM_HOLD1    = 3'd1,
    VM_HOLD0    = 3'd2,
    VM_SAME     = 3'd3,
    VM_INV      = 3'd4,
    VM_AGG_LATE = 3'd5,
    VM_VIC_LATE = 3'd6,
    VM_RSVD     = 3'd7
  } vmode_e;

  typedef enum logic [1:0] {
    VS_GLOBAL = 2'd0,
    VS_NIBBLE = 2'd1,
    VS_BYTE   = 2'd2,
    VS_ALL    = 2'd3
  } vsrc_e;
endpackage

// File: rtl/vxt_tap_line.sv
module vxt_tap_line #(
  parameter int DEPTH = 24,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tap_out
);
  localparam logic [SEL_W-1:0] TAP_MAX = SEL_W'(DEPTH);

  logic [DEPTH:1]   hist_q, hist_d;
  logic [SEL_W-1:0] tap_c;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) begin
      hist_d[1] = din;
      for (int k = 2; k <= DEPTH; k++) hist_d[k] = hist_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    tap_c   = (tap_sel > TAP_MAX) ? TAP_MAX : tap_sel;
    tap_out = (tap_c == '0) ? din : hist_q[tap_c];
  end
endmodule

// File: rtl/vxt_victim_mask.sv
module vxt_victim_mask
  import vxt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VIC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [1:0]        vsrc,
  input  logic [VIC_W-1:0]  glb_bit,
  output logic [DATA_W-1:0] mask
);
  localparam int POS_W = $clog2(DATA_W);
  localparam logic [POS_W-1:0] LAST_NIB = POS_W'(3);
  localparam logic [POS_W-1:0] LAST_BYT = POS_W'(7);
  localparam logic [POS_W-1:0] LAST_ALL = POS_W'(DATA_W-1);

  logic [POS_W-1:0] rot_q, rot_d, last_pos;

  always_comb begin
    case (vsrc_e'(vsrc))
      VS_NIBBLE: last_pos = LAST_NIB;
      VS_BYTE:   last_pos = LAST_BYT;
      default:   last_pos = LAST_ALL;
    endcase
    rot_d = rot_q;
    if (adv) rot_d = (rot_q >= last_pos) ? '0 : rot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rot_q <= '0;
    else        rot_q <= rot_d;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      case (vsrc_e'(vsrc))
        VS_GLOBAL: mask[i] = (glb_bit == VIC_W'(i));
        VS_NIBBLE: mask[i] = (rot_q == POS_W'(i % 4));
        VS_BYTE:   mask[i] = (rot_q == POS_W'(i % 8));
        default:   mask[i] = (rot_q == POS_W'(i));
      endcase
    end
  end
endmodule

// File: rtl/vxt_lane_mux.sv
module vxt_lane_mux
  import vxt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        mode,
  input  logic              cur_bit,
  input  logic              late_bit,
  input  logic [DATA_W-1:0] base_word,
  input  logic [DATA_W-1:0] vmask,
  output logic [DATA_W-1:0] word
);
  logic vic_v, agg_v, pass;

  always_comb begin
    pass  = 1'b0;
    vic_v = cur_bit;
    agg_v = cur_bit;
    case (vmode_e'(mode))
      VM_HOLD1:    agg_v = 1'b1;
      VM_HOLD0:    agg_v = 1'b0;
      VM_SAME:     agg_v = cur_bit;
      VM_INV:      agg_v = ~cur_bit;
      VM_AGG_LATE: agg_v = late_bit;
      VM_VIC_LATE: vic_v = late_bit;
      default:     pass  = 1'b1;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign word[i] = pass ? base_word[i] : (vmask[i] ? vic_v : agg_v);
  end
endmodule

// File: rtl/vxt_shaper.sv
module vxt_shaper #(
  parameter int DATA_W  = 32,
  parameter int DLY_MAX = 24,
  parameter int DLY_W   = 5,
  parameter int VIC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              base_bit,
  input  logic [DATA_W-1:0] base_word,
  input  logic [2:0]        mode,
  input  logic [DLY_W-1:0]  dly_cyc,
  input  logic [1:0]        vic_src,
  input  logic [VIC_W-1:0]  vic_bit,
  output logic              out_valid,
  output logic [DATA_W-1:0] data_out
);
  logic              late_bit;
  logic [DATA_W-1:0] vmask, shaped;
  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q, vld_d;

  vxt_tap_line #(.DEPTH(DLY_MAX), .SEL_W(DLY_W)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(base_bit),
    .tap_sel(dly_cyc), .tap_out(late_bit)
  );

  vxt_victim_mask #(.DATA_W(DATA_W), .VIC_W(VIC_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .vsrc(vic_src),
    .glb_bit(vic_bit), .mask(vmask)
  );

  vxt_lane_mux #(.DATA_W(DATA_W)) u_mux (
    .mode(mode), .cur_bit(base_bit), .late_bit(late_bit),
    .base_word(base_word), .vmask(vmask), .word(shaped)
  );

  always_comb begin
    vld_d  = in_valid;
    data_d = in_valid ? shaped : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign out_valid = vld_q;
  assign data_out  = data_q;
endmodule

// File: rtl/vxt_shaper_chk.sv
module vxt_shaper_chk #(
  parameter int DATA_W = 32,
  parameter int DLY_W  = 5,
  parameter int VIC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              base_bit,
  input logic [DATA_W-1:0] base_word,
  input logic [2:0]        mode,
  input logic [DLY_W-1:0]  dly_cyc,
  input logic [1:0]        vic_src,
  input logic [VIC_W-1:0]  vic_bit,
  input logic              out_valid,
  input logic [DATA_W-1:0] data_out
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(data_out)));
  // R3
  pass_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 3'd0)) |=> (data_out == $past(base_word)));
  // R4
  hold_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 3'd1) && (vic_src == 2'd3)) |=> ($countones(data_out) >= DATA_W-1));
  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 3'd2) && (vic_src == 2'd3)) |=> ($countones(data_out) <= 1));
  // R5
  same_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == 3'd3)) |=> (data_out == {DATA_W{$past(base_bit)}}));
endmodule

bind vxt_shaper vxt_shaper_chk #(.DATA_W(DATA_W), .DLY_W(DLY_W), .VIC_W(VIC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_bit(base_bit),
  .base_word(base_word), .mode(mode), .dly_cyc(dly_cyc), .vic_src(vic_src),
  .vic_bit(vic_bit), .out_valid(out_valid), .data_out(data_out)
);

// File: tb/vxt_shaper_test.sv
module vxt_shaper_test;
  localparam int CLK_PER = 10;
  localparam int W = 16;

  logic         clk, rst_n, in_valid, base_bit;
  logic [W-1:0] base_word, data_out;
  logic [2:0]   mode;
  logic [4:0]   dly_cyc;
  logic [1:0]   vic_src;
  logic [7:0]   vic_bit;
  logic         out_valid;

  int errors = 0, checks = 0;
  bit hist [0:24];
  int rot = 0;
  logic [15:0] lfsr = 16'hACE1;

  vxt_shaper #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_bit(base_bit),
    .base_word(base_word), .mode(mode), .dly_cyc(dly_cyc), .vic_src(vic_src),
    .vic_bit(vic_bit), .out_valid(out_valid), .data_out(data_out)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PER/2) clk = ~clk;
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic b, input logic [W-1:0] bw);
    logic [W-1:0] r;
    int n;
    logic late, vic, vv, av;
    n = (dly_cyc > 24) ? 24 : int'(dly_cyc);
    late = (n == 0) ? b : hist[n];
    if (mode == 3'd0 || mode == 3'd7) return bw;
    vv = b; av = b;
    case (mode)
      3'd1: av = 1'b1;
      3'd2: av = 1'b0;
      3'd4: av = ~b;
      3'd5: av = late;
      3'd6: vv = late;
      default: ;
    endcase
    for (int i = 0; i < W; i++) begin
      case (vic_src)
        2'd0: vic = (int'(vic_bit) == i);
        2'd1: vic = ((i % 4) == rot);
        2'd2: vic = ((i % 8) == rot);
        default: vic = (i == rot);
      endcase
      r[i] = vic ? vv : av;
    end
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; base_bit = 1'b0; base_word = '0;
    mode = 3'd0; dly_cyc = '0; vic_src = 2'd0; vic_bit = '0;
    for (int k = 0; k <= 24; k++) hist[k] = 1'b0;
    rot = 0;
    @(negedge clk);
    check("R1 data_out", data_out, '0);
    check("R1 out_valid", W'(out_valid), '0);
    rst_n = 1'b1;
  endtask

  task automatic step(input string req);
    logic [W-1:0] exp;
    int lim;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    base_bit = lfsr[0];
    base_word = lfsr ^ 16'h5A3C;
    in_valid = 1'b1;
    exp = model(base_bit, base_word);
    @(posedge clk);
    #1;
    check(req, data_out, exp);
    check("R2 out_valid", W'(out_valid), W'(1));
    for (int k = 24; k >= 2; k--) hist[k] = hist[k-1];
    hist[1] = base_bit;
    lim = (vic_src == 2'd1) ? 4 : (vic_src == 2'd2) ? 8 : W;
    rot = (rot >= lim-1) ? 0 : rot + 1;
  endtask

  task automatic t_pass();
    do_reset();
    mode = 3'd0;
    repeat (4) step("R3 mode0");
    mode = 3'd7;
    repeat (3) step("R3 mode7");
  endtask

  task automatic t_hold();
    do_reset();
    vic_src = 2'd0; vic_bit = 8'd5;
    mode = 3'd1; repeat (4) step("R4 R9 hold1");
    mode = 3'd2; repeat (4) step("R4 R9 hold0");
    vic_bit = 8'd20; mode = 3'd1;
    repeat (3) step("R9 no victim");
  endtask

  task automatic t_same_inv();
    do_reset();
    vic_src = 2'd1;
    mode = 3'd3; repeat (5) step("R5 R10 same");
    mode = 3'd4; repeat (9) step("R5 R10 inv");
  endtask

  task automatic t_agg_late();
    do_reset();
    vic_src = 2'd2; mode = 3'd5; dly_cyc = 5'd3;
    repeat (18) step("R6 R11 aggr late");
    dly_cyc = 5'd0;
    repeat (3) step("R6 tap0");
  endtask

  task automatic t_vic_late();
    do_reset();
    vic_src = 2'd3; mode = 3'd6; dly_cyc = 5'd24;
    repeat (36) step("R7 R12 victim late");
    dly_cyc = 5'd31;
    repeat (6) step("R8 clamp");
    mode = 3'd5;
    repeat (4) step("R8 clamp aggr");
  endtask

  task automatic t_idle();
    logic [W-1:0] held;
    do_reset();
    vic_src = 2'd3; mode = 3'd4;
    repeat (3) step("R12 pre-idle");
    held = data_out;
    @(negedge clk);
    in_valid = 1'b0; base_bit = ~base_bit; base_word = ~base_word;
    repeat (3) @(negedge clk);
    check("R2 idle hold", data_out, held);
    check("R2 idle valid", W'(out_valid), '0);
    repeat (3) step("R2 R12 resume");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    t_pass();
    t_hold();
    t_same_inv();
    t_agg_late();
    t_vic_late();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule